// File: doc/BRIEF.md
# Register-Driven Byte SPI Master

This block is a byte-wide SPI master that software drives through three 8-bit registers on a small internal register bus. The bus has a 16-bit address, 8-bit write and read data, and separate write and read strobes. A write to the command register sends one byte out on MOSI. The byte that arrives on MISO during that same shift is latched into the data register. The configuration register holds three things: a software-held chip-select override, an enable that arms command writes, and a busy flag that is visible only while the status check is enabled.

Chip select is not pulsed for each byte. It stays low for as long as software keeps the override bit set, so a multi-byte flash command is framed by setting the bit, issuing several byte transfers and then clearing it. To receive a byte, software writes a dummy 0x00 to the command register, waits until busy reads 0, and then reads the data register. The serial clock comes from the system clock through a parameterised divider, `DIV`, which must be even; the default is 4.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, the data register reads 0x00 and the config register reads 0x00.
- R2: The data register is at address 0xFEAB, the command register at 0xFEAC and the config register at 0xFEAD. A read of any other address returns 0x00, and a write to any other address changes no register.
- R3: cs_n is low exactly while config bit 4 is set. It stays low across any number of byte transfers until software clears that bit.
- R4: A command-register write starts a transfer only while config bit 3 is set. When bit 3 is clear, the write produces no sck edge and does not set busy.
- R5: Each transfer uses SPI mode 0. sck idles low and gives 8 pulses of DIV system clocks each. MOSI carries the command byte MSB first and changes only on the falling edge, and MISO is sampled on each rising edge.
- R6: With config bit 0 set, config bit 1 reads 1 from the clock edge that accepts the command write until exactly 8*DIV cycles later, and reads 0 after that.
- R7: With config bit 0 clear, config bit 1 reads 0 even while a byte is shifting.
- R8: When a transfer completes, the data register holds the 8 bits sampled on MISO, first-sampled bit in bit 7. A dummy 0x00 command reads a byte this way.
- R9: A command-register write while a transfer is in progress is ignored. It neither changes the byte being sent nor shortens or extends the transfer.
- R10: Config reads return bits 4, 3 and 0 as last written, bit 1 as the status, and 0 in bits 7..5 and 2.
- R11: A transfer launched 4 cycles after a chip-select change through the config register completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data, 0 when no read strobe is active |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Register writes take effect on the clock edge that samples the strobe. Reads are combinational, so the bench samples them a little after a falling clock edge. Busy must read 1 after the 8*DIV-1th edge that follows the accepting edge and 0 after the 8*DIV-th edge. The bench counts edges from the accepting edge and reads the config register at exactly those two points. For each transfer, a bench-side slave model counts sck rising edges and collects MOSI, and the bench compares the result with the command byte. The data register is read only after the completion point and is compared with the byte the slave model presented.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int          DIV       = 4,
  parameter logic [15:0] ADDR_DATA = 16'hFEAB,
  parameter logic [15:0] ADDR_CMD  = 16'hFEAC,
  parameter logic [15:0] ADDR_CFG  = 16'hFEAD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic          cfg_cs, cfg_wen, cfg_chk;
  logic          busy;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sh, rx_sh, data_q;

  wire hit_cmd  = bus_wr && (bus_addr == ADDR_CMD);
  wire hit_cfg  = bus_wr && (bus_addr == ADDR_CFG);
  wire launch   = hit_cmd && cfg_wen && !busy;
  wire div_end  = busy && (div_cnt == HALF_LAST);
  wire sck_fall = div_end && sck;
  wire sck_rise = div_end && !sck;
  wire status   = busy && cfg_chk;

  assign cs_n = !cfg_cs;
  assign mosi = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cs  <= 1'b0;
      cfg_wen <= 1'b0;
      cfg_chk <= 1'b0;
    end else if (hit_cfg) begin
      cfg_cs  <= bus_wdata[4];
      cfg_wen <= bus_wdata[3];
      cfg_chk <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      data_q  <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= bus_wdata;
    end else if (busy) begin
      if (!div_end) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        sck     <= !sck;
        if (sck_rise) begin
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          tx_sh   <= {tx_sh[6:0], 1'b0};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            busy   <= 1'b0;
            data_q <= rx_sh;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (bus_addr == ADDR_DATA)
        bus_rdata = data_q;
      else if (bus_addr == ADDR_CFG)
        bus_rdata = {3'b000, cfg_cs, cfg_wen, 1'b0, status, cfg_chk};
    end
  end

  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));

  a_r9_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sck_fall) |=> $stable(tx_sh));

  a_r6_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bit_cnt) == 3'd7 && $past(sck)));

  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(data_q));

  a_r3_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cfg) |=> (cs_n == !$past(bus_wdata[4])));

  initial begin
    a_r5_div_even: assert (DIV >= 2 && DIV % 2 == 0);
  end
endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int XFER = 8 * DIV;
  localparam logic [15:0] A_DATA = 16'hFEAB;
  localparam logic [15:0] A_CMD  = 16'hFEAC;
  localparam logic [15:0] A_CFG  = 16'hFEAD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic sck, mosi, cs_n, miso;

  int errors = 0, checks = 0;
  int rises = 0, cs_high_rises = 0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  logic [7:0] rd;

  spi_byte_master #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = !clk;

  assign miso = slv_tx[7];
  always @(posedge sck) begin
    slv_rx = {slv_rx[6:0], mosi};
    rises = rises + 1;
    if (cs_n) cs_high_rises = cs_high_rises + 1;
  end
  always @(negedge sck) slv_tx = {slv_tx[6:0], 1'b0};

  function automatic logic [7:0] exp_cfg(input logic cs, input logic wen,
                                         input logic chk, input logic bsy);
    return {3'b000, cs, wen, 1'b0, bsy & chk, chk};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // Launch one byte and check busy timing at 8*DIV-1 and 8*DIV edges.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv,
                      input logic chk, input logic cs);
    int r0;
    slv_tx = slv;
    r0 = rises;
    bus_write(A_CMD, tx);
    repeat (XFER - 1) @(posedge clk);
    #2 bus_read(A_CFG, rd);
    check("R6 busy before end", rd, exp_cfg(cs, 1'b1, chk, 1'b1));
    @(posedge clk);
    #2 bus_read(A_CFG, rd);
    check("R6 busy cleared", rd, exp_cfg(cs, 1'b1, chk, 1'b0));
    check("R5 mosi byte", slv_rx, tx);
    check("R5 sck pulses", 8'(rises - r0), 8'd8);
    bus_read(A_DATA, rd);
    check("R8 captured miso", rd, slv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed, r0;
    logic [7:0] tx, sv;
    logic chk;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    check("R1 cs_n", {7'b0, cs_n}, 8'd1);
    check("R1 sck", {7'b0, sck}, 8'd0);
    bus_read(A_DATA, rd); check("R1 data", rd, 8'h00);
    bus_read(A_CFG, rd);  check("R1 cfg", rd, 8'h00);
    rst_n = 1'b1;

    bus_write(A_CFG, 8'hFF);
    #2 bus_read(A_CFG, rd); check("R10 cfg readback ff", rd, 8'h19);
    check("R3 cs low", {7'b0, cs_n}, 8'd0);
    bus_write(16'hFEAE, 8'h00);
    #2 bus_read(A_CFG, rd); check("R2 other addr write", rd, 8'h19);
    bus_read(16'hFEAA, rd); check("R2 other addr read", rd, 8'h00);
    bus_write(A_CFG, 8'h00);
    #2 bus_read(A_CFG, rd); check("R10 cfg readback 00", rd, 8'h00);
    check("R3 cs high", {7'b0, cs_n}, 8'd1);

    // R4: command write without enable
    r0 = rises;
    bus_write(A_CFG, 8'h11);
    bus_write(A_CMD, 8'hA5);
    #2 bus_read(A_CFG, rd); check("R4 no busy", rd, 8'h11);
    repeat (XFER + 4) @(posedge clk);
    check("R4 no sck", 8'(rises - r0), 8'd0);

    // R11: launch 4 cycles after cs edge
    bus_write(A_CFG, 8'h00);
    bus_write(A_CFG, 8'h19);
    repeat (3) @(posedge clk);
    xfer(8'h9F, 8'hC2, 1'b1, 1'b1);
    check("R11 cs held", {7'b0, cs_n}, 8'd0);
    // R8: dummy read
    xfer(8'h00, 8'h3C, 1'b1, 1'b1);
    xfer(8'h00, 8'hFF, 1'b1, 1'b1);

    // R9: write while busy ignored
    slv_tx = 8'h81;
    r0 = rises;
    bus_write(A_CMD, 8'h5A);
    repeat (9) @(posedge clk);
    bus_write(A_CMD, 8'hE7);
    repeat (XFER - 11) @(posedge clk);
    #2 bus_read(A_CFG, rd); check("R9 busy kept", rd, 8'h1B);
    @(posedge clk);
    #2 bus_read(A_CFG, rd); check("R9 ends on time", rd, 8'h19);
    check("R9 byte kept", slv_rx, 8'h5A);
    check("R9 pulses", 8'(rises - r0), 8'd8);
    bus_read(A_DATA, rd); check("R9 data", rd, 8'h81);

    // R7: status masked
    bus_write(A_CFG, 8'h18);
    slv_tx = 8'h00;
    bus_write(A_CMD, 8'h77);
    repeat (5) @(posedge clk);
    #2 bus_read(A_CFG, rd); check("R7 status masked", rd, 8'h18);
    repeat (XFER) @(posedge clk);

    // Random multi-byte frames with cs held
    for (int f = 0; f < 6; f++) begin
      chk = 1'($urandom);
      bus_write(A_CFG, {3'b000, 2'b11, 2'b00, chk});
      repeat (4) @(posedge clk);
      for (int b = 0; b < 4; b++) begin
        tx = 8'($urandom); sv = 8'($urandom);
        xfer(tx, sv, chk, 1'b1);
      end
      check("R3 cs low across frame", {7'b0, cs_n}, 8'd0);
      bus_write(A_CFG, {3'b000, 2'b01, 2'b00, chk});
      #2 check("R3 cs released", {7'b0, cs_n}, 8'd1);
    end
    check("R3 no sck with cs high", 8'(cs_high_rises), 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule